// File: doc/BRIEF.md
# Continuous SPI Thermocouple Frame Reader

This block is a free-running SPI master for a read-only thermocouple converter that returns a 32-bit frame. It has no start request and no handshake. A single step counter runs a fixed 36-step sequence and then wraps, so a new frame starts again and again.

Each frame has four phases:
- Chip select is held inactive for two steps.
- Chip select goes active and 32 serial bits are shifted in, most significant bit first.
- The finished word is copied into a 32-bit output register.
- Chip select goes inactive again.

The SPI clock pin is the system clock, passed straight through. A one-cycle strobe marks every fresh word. An 8-bit integer temperature field is taken from the held word for a display or control path downstream.

The output register keeps its value while the next frame is being collected. A consumer can therefore read the word at any time and use the strobe only to count updates.

Top module: `spiThermoReader`

## Requirements
- R1: With reset low, a frame lasts exactly 36 clock cycles. A new frame starts with no external request, so `newWord` pulses once every 36 cycles. The first pulse after reset is released appears in the 35th cycle.
- R2: `spiCsN` is high (inactive) in the two steps that open a frame and in the two steps that close it. It is low for exactly 32 consecutive cycles per frame.
- R3: `spiMiso` is sampled on the rising edge of `clk` once in each of the 32 chip-select-low cycles. The first sample is the device's bit 31. After the load, bit 31 of `dataOut` holds the first sample and bit 0 holds the last.
- R4: `dataOut` changes only in the cycle in which `newWord` is high. At all other times it holds the last completed word.
- R5: `newWord` is high for exactly one cycle per frame. In that cycle `dataOut` already shows the new word.
- R6: `tempInt` always equals bits 28 down to 21 of `dataOut`, with bit 28 as the MSB of `tempInt`.
- R7: `spiClk` follows `clk` with no division: it is low while `clk` is low and high while `clk` is high.
- R8: A synchronous, active-high `rst` restarts the sequence at its first step. While `rst` is held, `dataOut` is 0, `newWord` is 0 and `spiCsN` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also drives the SPI clock pin |
| rst | input | 1 | Synchronous reset, active high |
| spiMiso | input | 1 | Serial data from the converter |
| spiClk | output | 1 | SPI clock, equal to `clk` |
| spiCsN | output | 1 | Chip select, active low |
| dataOut | output | 32 | Last completed frame word |
| newWord | output | 1 | One-cycle strobe when `dataOut` is reloaded |
| tempInt | output | 8 | Integer temperature field of `dataOut` |

## Verification
A model of the converter shifts out a chosen word, starting at bit 31, on every chip-select-low cycle.

The test words are chosen so that each one separates a different fault:
- Alternating patterns and a single set MSB or LSB reveal bit reversal and off-by-one sampling.
- All ones and all zeros reveal a stuck input or a failure to reload.
- A word whose only set bits lie inside bits 28..21 separates the temperature field from its neighbours.

Cycle counts between strobes and between chip-select edges check the step boundaries. A reset in the middle of a frame checks that the sequence restarts cleanly.

// File: rtl/spiThermoPkg.sv
package spiThermoPkg;

  typedef struct packed {
    logic clearBuf;
    logic shiftEn;
    logic loadOut;
  } ctrlStrobes_t;

endpackage

// File: rtl/spiThermoCtrl.sv
module spiThermoCtrl
  import spiThermoPkg::*;
#(
  parameter int LEAD_STEPS = 2,
  parameter int FRAME_BITS = 32,
  parameter int TAIL_STEPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  output ctrlStrobes_t strobes,
  output logic         csN
);

  localparam int TOTAL_STEPS = LEAD_STEPS + FRAME_BITS + TAIL_STEPS;
  localparam int STEP_W      = $clog2(TOTAL_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP  = STEP_W'(TOTAL_STEPS - 1);
  localparam logic [STEP_W-1:0] DATA_FIRST = STEP_W'(LEAD_STEPS);
  localparam logic [STEP_W-1:0] LOAD_STEP  = STEP_W'(LEAD_STEPS + FRAME_BITS);

  logic [STEP_W-1:0] stepQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stepQ <= '0;
    end else if (stepQ == LAST_STEP) begin
      stepQ <= '0;
    end else begin
      stepQ <= stepQ + 1'b1;
    end
  end

  always_comb begin
    strobes.clearBuf = (stepQ < DATA_FIRST);
    strobes.shiftEn  = (stepQ >= DATA_FIRST) && (stepQ < LOAD_STEP);
    strobes.loadOut  = (stepQ == LOAD_STEP);
    csN              = !strobes.shiftEn;
  end

endmodule

// File: rtl/spiThermoData.sv
module spiThermoData
  import spiThermoPkg::*;
#(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctrlStrobes_t          strobes,
  input  logic                  serialIn,
  output logic [FRAME_BITS-1:0] wordOut,
  output logic                  wordValid
);

  logic [FRAME_BITS-1:0] shiftQ;
  logic [FRAME_BITS-1:0] holdQ;
  logic                  validQ;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearBuf) begin
      shiftQ <= '0;
    end else if (strobes.shiftEn) begin
      shiftQ <= {shiftQ[FRAME_BITS-2:0], serialIn};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdQ  <= '0;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.loadOut;
      if (strobes.loadOut) begin
        holdQ <= shiftQ;
      end
    end
  end

  assign wordOut   = holdQ;
  assign wordValid = validQ;

endmodule

// File: rtl/spiThermoReader.sv
module spiThermoReader
  import spiThermoPkg::*;
#(
  parameter int LEAD_STEPS = 2,
  parameter int FRAME_BITS = 32,
  parameter int TAIL_STEPS = 2,
  parameter int TEMP_MSB   = 28,
  parameter int TEMP_LSB   = 21
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          spiMiso,
  output logic                          spiClk,
  output logic                          spiCsN,
  output logic [FRAME_BITS-1:0]         dataOut,
  output logic                          newWord,
  output logic [TEMP_MSB-TEMP_LSB:0]    tempInt
);

  ctrlStrobes_t strobes;

  spiThermoCtrl #(
    .LEAD_STEPS(LEAD_STEPS),
    .FRAME_BITS(FRAME_BITS),
    .TAIL_STEPS(TAIL_STEPS)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .csN    (spiCsN)
  );

  spiThermoData #(
    .FRAME_BITS(FRAME_BITS)
  ) i_data (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .serialIn (spiMiso),
    .wordOut  (dataOut),
    .wordValid(newWord)
  );

  assign spiClk  = clk;
  assign tempInt = dataOut[TEMP_MSB:TEMP_LSB];

endmodule

// File: rtl/spiThermoReaderChk.sv
module spiThermoReaderChk #(
  parameter int LEAD_STEPS = 2,
  parameter int FRAME_BITS = 32,
  parameter int TAIL_STEPS = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  spiCsN,
  input logic [FRAME_BITS-1:0] dataOut,
  input logic                  newWord
);

  localparam int TOTAL_STEPS = LEAD_STEPS + FRAME_BITS + TAIL_STEPS;
  localparam int CNT_W       = $clog2(TOTAL_STEPS + 1) + 1;

  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] gapCnt;
  logic             seenPulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowCnt    <= '0;
      gapCnt    <= '0;
      seenPulse <= 1'b0;
    end else begin
      lowCnt <= spiCsN ? '0 : lowCnt + 1'b1;
      gapCnt <= newWord ? CNT_W'(1) : gapCnt + 1'b1;
      if (newWord) seenPulse <= 1'b1;
    end
  end

  // R1: steady period between strobes
  a_r1_period: assert property (@(posedge clk) disable iff (rst)
    (newWord && seenPulse) |-> (gapCnt == CNT_W'(TOTAL_STEPS)));

  // R1: first strobe after reset release
  a_r1_first: assert property (@(posedge clk) disable iff (rst)
    (newWord && !seenPulse) |-> (gapCnt == CNT_W'(TOTAL_STEPS - 1)));

  // R2: chip select low window length
  a_r2_low_window: assert property (@(posedge clk) disable iff (rst)
    $rose(spiCsN) |-> (lowCnt == CNT_W'(FRAME_BITS)));

  // R2: chip select stays high at least two cycles
  a_r2_high_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(spiCsN) |=> spiCsN);

  // R4: output changes only with the strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(dataOut) |-> newWord);

  // R5: strobe lasts one cycle
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    newWord |=> !newWord);

  // R8: reset state
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (spiCsN && !newWord && (dataOut == '0)));

endmodule

bind spiThermoReader spiThermoReaderChk #(
  .LEAD_STEPS(LEAD_STEPS),
  .FRAME_BITS(FRAME_BITS),
  .TAIL_STEPS(TAIL_STEPS)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .spiCsN (spiCsN),
  .dataOut(dataOut),
  .newWord(newWord)
);

// File: tb/test_spiThermoReader.sv
`timescale 1ns/1ps
module test_spiThermoReader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spiMiso;
  logic        spiClk;
  logic        spiCsN;
  logic [31:0] dataOut;
  logic        newWord;
  logic [7:0]  tempInt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] devWord = 32'h0;
  logic [4:0]  bitIdx  = 5'd31;

  always #2.5 clk = ~clk;

  spiThermoReader i_spiThermoReader (
    .clk    (clk),
    .rst    (rst),
    .spiMiso(spiMiso),
    .spiClk (spiClk),
    .spiCsN (spiCsN),
    .dataOut(dataOut),
    .newWord(newWord),
    .tempInt(tempInt)
  );

  // converter model: MSB presented while select is high, next bit after each sample
  always @(posedge clk) begin
    if (spiCsN) bitIdx <= 5'd31;
    else        bitIdx <= bitIdx - 5'd1;
  end
  assign spiMiso = devWord[bitIdx];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitPulse(output int cycles);
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!newWord && cycles < 200);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(dataOut == 32'h0, "R8 dataOut", dataOut, 32'h0);
    check(newWord == 1'b0, "R8 newWord", {31'h0, newWord}, 32'h0);
    check(spiCsN == 1'b1, "R8 spiCsN", {31'h0, spiCsN}, 32'h1);
  endtask

  task automatic testFirstFrame(input logic [31:0] w);
    int n;
    devWord = w;
    rst = 1'b0;
    waitPulse(n);
    check(n == 35, "R1 first strobe cycle", n, 35);
    check(dataOut == w, "R3 first word", dataOut, w);
  endtask

  // strobe is sitting at the current negedge: load next word, check next frame
  task automatic testWord(input logic [31:0] w);
    int n;
    logic [31:0] held;
    devWord = w;
    held = dataOut;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!newWord) begin
        if (dataOut !== held) check(1'b0, "R4 hold", dataOut, held);
      end
    end while (!newWord && n < 200);
    check(n == 36, "R1 period", n, 36);
    check(dataOut == w, "R3 word", dataOut, w);
    check(tempInt == w[28:21], "R6 temp field", {24'h0, tempInt}, {24'h0, w[28:21]});
    @(negedge clk);
    check(newWord == 1'b0, "R5 single strobe", {31'h0, newWord}, 32'h0);
    check(dataOut == w, "R4 held after strobe", dataOut, w);
    do @(negedge clk); while (!newWord);
  endtask

  task automatic testCsPattern();
    int lowRun;
    int maxRun;
    // at strobe negedge (closing step)
    check(spiCsN == 1'b1, "R2 cs high closing", {31'h0, spiCsN}, 32'h1);
    @(negedge clk);
    check(spiCsN == 1'b1, "R2 cs high step0", {31'h0, spiCsN}, 32'h1);
    @(negedge clk);
    check(spiCsN == 1'b1, "R2 cs high step1", {31'h0, spiCsN}, 32'h1);
    lowRun = 0;
    maxRun = 0;
    for (int k = 0; k < 34; k++) begin
      @(negedge clk);
      if (!spiCsN) lowRun++;
      if (lowRun > maxRun) maxRun = lowRun;
    end
    check(maxRun == 32, "R2 cs low count", maxRun, 32);
    check(spiCsN == 1'b1, "R2 cs high at load", {31'h0, spiCsN}, 32'h1);
    do @(negedge clk); while (!newWord);
  endtask

  task automatic testClock();
    @(negedge clk);
    #1;
    check(spiClk == 1'b0, "R7 clk low", {31'h0, spiClk}, 32'h0);
    @(posedge clk);
    #1;
    check(spiClk == 1'b1, "R7 clk high", {31'h0, spiClk}, 32'h1);
    do @(negedge clk); while (!newWord);
  endtask

  task automatic testMidReset(input logic [31:0] w);
    int n;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(dataOut == 32'h0, "R8 mid-frame dataOut", dataOut, 32'h0);
    check(spiCsN == 1'b1, "R8 mid-frame cs", {31'h0, spiCsN}, 32'h1);
    devWord = w;
    rst = 1'b0;
    waitPulse(n);
    check(n == 35, "R8 restart strobe cycle", n, 35);
    check(dataOut == w, "R8 restart word", dataOut, w);
  endtask

  initial begin
    testReset();
    testFirstFrame(32'h8000_0001);
    testWord(32'hAAAA_5555);
    testWord(32'h5555_AAAA);
    testWord(32'hFFFF_FFFF);
    testWord(32'h0000_0000);
    testWord(32'h1FE0_0000);
    testWord(32'h0000_0001);
    testWord(32'h1234_ABCD);
    testCsPattern();
    testClock();
    testMidReset(32'hC3A5_0F96);
    testWord(32'h0A60_0000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule